// File: doc/BRIEF.md
# Snooping Bus Coherence Controller

This block keeps a group of small direct-mapped caches coherent across one shared bus. Each cache sits behind its own controller. The controller serves a blocking processor port. It requests the bus from a round-robin arbiter when a request cannot finish locally. It also watches every transaction that another cache puts on the bus. Main memory is outside the block and is reached through a read port and a write port that the bus drives. Memory answers a read in the same cycle.

Every line is in one of three states. `LN_INV` means the line is empty. `LN_SHR` means a clean copy that other caches may also hold. `LN_MOD` means the only copy, and it is dirty. A parameter selects the write policy. In invalidate mode, a write removes every other copy, and a dirty owner hands its data straight to a cache that misses. In the same transaction that owner's data is also written to memory. In update mode, every write goes on the bus. The write refreshes the other copies and writes memory, so lines never become dirty.

Each controller runs a three-state machine:
- `CT_IDLE`: takes a request and moves to `CT_RESP` on a local hit. On a miss, or on a write that needs the bus, it moves to `CT_BUS`. It stays in `CT_IDLE` when a snoop hits the same index in that cycle.
- `CT_BUS`: requests the bus. The bus operation is chosen in the cycle the grant is held. The choices are `OP_WBACK` (dirty victim), `OP_READ` (read miss), `OP_READX` (write miss), `OP_INVAL` (write to a shared line) and `OP_UPDATE` (any write in update mode). After `OP_WBACK` the machine stays in `CT_BUS`. After any other operation it moves to `CT_RESP`.
- `CT_RESP`: raises done for one cycle, then returns to `CT_IDLE`.

Top module: `snoop_coherence_top`

## Requirements
- R1: After reset every line is `LN_INV`, no grant is active and memory is not written. A read miss fetches the word from memory, installs it as `LN_SHR` and returns it.
- R2: A read hit returns the cached word without a bus transaction or a memory access.
- R3: In invalidate mode, a write to a `LN_SHR` line wins the bus for one `OP_INVAL` before the local word changes. Every other copy of that address becomes `LN_INV`, and memory is not written.
- R4: In invalidate mode, a write miss issues `OP_READX`, which invalidates all other copies. The requester ends with the line `LN_MOD` holding the new word.
- R5: When a read miss hits a line that another cache holds `LN_MOD`, the owner supplies the word, memory is written with it in the same transaction, memory is not read, and the owner drops to `LN_SHR`.
- R6: A miss whose direct-mapped slot holds a `LN_MOD` line of a different address first writes that line back to memory in its own transaction, then fetches.
- R7: In update mode, every write, hit or miss, issues `OP_UPDATE`. It writes memory and refreshes other copies, and the writer keeps the line `LN_SHR`. A later read by a sharer hits with the new word.
- R8: At most one cache holds the bus grant, and a grant stays put until its transaction completes. Each transaction lasts one cycle.
- R9: Grants rotate round-robin. After reset cache 0 has the highest priority, and after a grant to cache k, cache k+1 (wrapping) has it.
- R10: At most one cache holds a given address `LN_MOD`, so at most one owner answers a bus read.
- R11: In invalidate mode, a write hit to a `LN_MOD` line completes locally with no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_req | input | NCACHE | Request per cache, held until done |
| proc_we | input | NCACHE | 1 = write, 0 = read, per cache |
| proc_addr | input | NCACHE*ADDR_W | Word address per cache (cache i at bits i*ADDR_W) |
| proc_wdata | input | NCACHE*DATA_W | Write data per cache |
| proc_done | output | NCACHE | One-cycle completion pulse per cache |
| proc_rdata | output | NCACHE*DATA_W | Read data per cache, valid with done |
| bus_gnt | output | NCACHE | One-hot bus grant |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address for read and write |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |

## Verification
Some rules are checked on every cycle by assertions:
- The grant stays one-hot and does not move mid-transaction.
- No bus read ever finds two dirty owners.
- A snooped invalidate actually removes the matching line.
- Every completed write in invalidate mode leaves its line dirty.
- No line turns dirty in update mode.

Other behaviour only shows up in the bench's scenarios, which track the data values against a behavioural model of memory and of the last write to each address:
- owner-to-cache supply with its memory write;
- the write-back of a dirty victim;
- whether a request used the bus at all;
- the exact round-robin grant order under contention.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {LN_INV, LN_SHR, LN_MOD} line_st_e;
    typedef enum logic [2:0] {OP_READ, OP_READX, OP_INVAL, OP_UPDATE, OP_WBACK} bus_op_e;
    typedef enum logic [1:0] {CT_IDLE, CT_BUS, CT_RESP} ctrl_st_e;
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         last,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [N-1:0]  pick;
    logic [PW-1:0] pick_idx;
    logic          found;

    always_comb begin
        pick     = '0;
        pick_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            int k;
            k = int'(ptr) + i;
            if (k >= N) k = k - N;
            if (!found && req[k]) begin
                found    = 1'b1;
                pick[k]  = 1'b1;
                pick_idx = PW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt <= '0;
            ptr <= '0;
        end else if (gnt != '0) begin
            if (last) gnt <= '0;
        end else if (found) begin
            gnt <= pick;
            ptr <= (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
        end
    end

    // R8: grant is one-hot and held until the transaction finishes
    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt))
        else $error("grant not one-hot");
    assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !last) |=> $stable(gnt))
        else $error("grant moved before transaction end");
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int LINES       = 4,
    parameter bit UPDATE_MODE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          proc_req,
    input  logic          proc_we,
    input  logic [AW-1:0] proc_addr,
    input  logic [DW-1:0] proc_wdata,
    output logic          proc_done,
    output logic [DW-1:0] proc_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output bus_op_e       bus_op,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          snp_valid,
    input  bus_op_e       snp_op,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_wdata,
    output logic          snp_dirty,
    output logic [DW-1:0] snp_data,
    input  logic [DW-1:0] fill_data
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    ctrl_st_e      state, state_nx;
    line_st_e      lst   [LINES];
    logic [TW-1:0] ltag  [LINES];
    logic [DW-1:0] ldata [LINES];

    logic          pend_we;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_wdata;
    logic [DW-1:0] rdata_q;

    logic [AW-1:0] a_addr;
    logic [IW-1:0] a_idx, s_idx;
    logic [TW-1:0] a_tag, s_tag;
    logic          tag_eq, hit, s_hit, clash, is_local, local_go;

    always_comb begin
        a_addr   = (state == CT_IDLE) ? proc_addr : pend_addr;
        a_idx    = a_addr[IW-1:0];
        a_tag    = a_addr[AW-1:IW];
        tag_eq   = (ltag[a_idx] == a_tag);
        hit      = (lst[a_idx] != LN_INV) && tag_eq;
        s_idx    = snp_addr[IW-1:0];
        s_tag    = snp_addr[AW-1:IW];
        s_hit    = snp_valid && (lst[s_idx] != LN_INV) && (ltag[s_idx] == s_tag);
        clash    = snp_valid && (s_idx == a_idx);
        is_local = hit && (!proc_we || (lst[a_idx] == LN_MOD && !UPDATE_MODE));
        local_go = (state == CT_IDLE) && proc_req && is_local && !clash;
    end

    assign snp_dirty = s_hit && (lst[s_idx] == LN_MOD);
    assign snp_data  = ldata[s_idx];

    // bus operation decided while the grant is held, from current line state
    always_comb begin
        bus_addr  = pend_addr;
        bus_wdata = pend_wdata;
        if (lst[a_idx] == LN_MOD && !tag_eq) begin
            bus_op    = OP_WBACK;
            bus_addr  = {ltag[a_idx], a_idx};
            bus_wdata = ldata[a_idx];
        end else if (UPDATE_MODE && pend_we) begin
            bus_op = OP_UPDATE;
        end else if (!pend_we) begin
            bus_op = OP_READ;
        end else if (hit) begin
            bus_op = OP_INVAL;
        end else begin
            bus_op = OP_READX;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CT_IDLE: if (proc_req) begin
                if (!is_local)  state_nx = CT_BUS;
                else if (!clash) state_nx = CT_RESP;
            end
            CT_BUS:  if (bus_gnt && bus_op != OP_WBACK) state_nx = CT_RESP;
            CT_RESP: state_nx = CT_IDLE;
            default: state_nx = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        bus_req    = (state == CT_BUS);
        proc_done  = (state == CT_RESP);
        proc_rdata = rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_we    <= 1'b0;
            pend_addr  <= '0;
            pend_wdata <= '0;
            rdata_q    <= '0;
            for (int i = 0; i < LINES; i++) begin
                lst[i]   <= LN_INV;
                ltag[i]  <= '0;
                ldata[i] <= '0;
            end
        end else begin
            if (state == CT_IDLE && proc_req) begin
                pend_we    <= proc_we;
                pend_addr  <= proc_addr;
                pend_wdata <= proc_wdata;
            end
            if (s_hit) begin
                unique case (snp_op)
                    OP_READ:            if (lst[s_idx] == LN_MOD) lst[s_idx] <= LN_SHR;
                    OP_READX, OP_INVAL: lst[s_idx] <= LN_INV;
                    OP_UPDATE:          ldata[s_idx] <= snp_wdata;
                    default: ;
                endcase
            end
            if (local_go) begin
                if (proc_we) ldata[a_idx] <= proc_wdata;
                else         rdata_q      <= ldata[a_idx];
            end
            if (state == CT_BUS && bus_gnt) begin
                unique case (bus_op)
                    OP_WBACK: lst[a_idx] <= LN_INV;
                    OP_READ: begin
                        lst[a_idx]   <= LN_SHR;
                        ltag[a_idx]  <= a_tag;
                        ldata[a_idx] <= fill_data;
                        rdata_q      <= fill_data;
                    end
                    OP_READX, OP_INVAL: begin
                        lst[a_idx]   <= LN_MOD;
                        ltag[a_idx]  <= a_tag;
                        ldata[a_idx] <= pend_wdata;
                    end
                    OP_UPDATE: begin
                        lst[a_idx]   <= LN_SHR;
                        ltag[a_idx]  <= a_tag;
                        ldata[a_idx] <= pend_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // checker state: remember a snooped invalidating hit
    logic          inv_q;
    logic [AW-1:0] inv_addr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q      <= 1'b0;
            inv_addr_q <= '0;
        end else begin
            inv_q      <= s_hit && (snp_op == OP_READX || snp_op == OP_INVAL);
            inv_addr_q <= snp_addr;
        end
    end

    assert_snoop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q |-> !(lst[inv_addr_q[IW-1:0]] != LN_INV && ltag[inv_addr_q[IW-1:0]] == inv_addr_q[AW-1:IW]))
        else $error("snooped invalidate left a valid copy");

    assert_write_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CT_RESP && pend_we && !UPDATE_MODE) |->
        (lst[pend_addr[IW-1:0]] == LN_MOD && ltag[pend_addr[IW-1:0]] == pend_addr[AW-1:IW]))
        else $error("completed write did not leave line modified");

    for (genvar k = 0; k < LINES; k++) begin : g_upd_chk
        if (UPDATE_MODE) begin : g_on
            assert_update_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
                lst[k] != LN_MOD)
                else $error("dirty line in update mode");
        end
    end
endmodule

// File: rtl/snoop_coherence_top.sv
module snoop_coherence_top
    import coh_pkg::*;
#(
    parameter int NCACHE      = 3,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int LINES       = 4,
    parameter bit UPDATE_MODE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCACHE-1:0]        proc_req,
    input  logic [NCACHE-1:0]        proc_we,
    input  logic [NCACHE*ADDR_W-1:0] proc_addr,
    input  logic [NCACHE*DATA_W-1:0] proc_wdata,
    output logic [NCACHE-1:0]        proc_done,
    output logic [NCACHE*DATA_W-1:0] proc_rdata,
    output logic [NCACHE-1:0]        bus_gnt,
    output logic                     mem_rd_en,
    output logic                     mem_wr_en,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata
);
    logic [NCACHE-1:0] c_req, c_dirty;
    bus_op_e           c_op    [NCACHE];
    logic [ADDR_W-1:0] c_addr  [NCACHE];
    logic [DATA_W-1:0] c_wdata [NCACHE];
    logic [DATA_W-1:0] c_sdata [NCACHE];

    logic              b_valid, own_any, is_rd;
    bus_op_e           b_op;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata, own_data, fill;

    always_comb begin
        b_valid  = 1'b0;
        b_op     = OP_READ;
        b_addr   = '0;
        b_wdata  = '0;
        own_data = '0;
        for (int i = 0; i < NCACHE; i++) begin
            if (bus_gnt[i]) begin
                b_valid = c_req[i];
                b_op    = c_op[i];
                b_addr  = c_addr[i];
                b_wdata = c_wdata[i];
            end
            if (c_dirty[i]) own_data = c_sdata[i];
        end
        own_any   = |c_dirty;
        is_rd     = (b_op == OP_READ) || (b_op == OP_READX);
        fill      = own_any ? own_data : mem_rdata;
        mem_addr  = b_addr;
        mem_rd_en = b_valid && is_rd && !own_any;
        mem_wr_en = b_valid && ((is_rd && own_any) || b_op == OP_WBACK || b_op == OP_UPDATE);
        mem_wdata = own_any ? own_data : b_wdata;
    end

    coh_rr_arbiter #(.N(NCACHE)) arb_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (c_req),
        .last (b_valid),
        .gnt  (bus_gnt)
    );

    for (genvar i = 0; i < NCACHE; i++) begin : g_cache
        coh_cache_ctrl #(
            .AW(ADDR_W), .DW(DATA_W), .LINES(LINES), .UPDATE_MODE(UPDATE_MODE)
        ) ctrl_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .proc_req  (proc_req[i]),
            .proc_we   (proc_we[i]),
            .proc_addr (proc_addr[i*ADDR_W +: ADDR_W]),
            .proc_wdata(proc_wdata[i*DATA_W +: DATA_W]),
            .proc_done (proc_done[i]),
            .proc_rdata(proc_rdata[i*DATA_W +: DATA_W]),
            .bus_req   (c_req[i]),
            .bus_gnt   (bus_gnt[i]),
            .bus_op    (c_op[i]),
            .bus_addr  (c_addr[i]),
            .bus_wdata (c_wdata[i]),
            .snp_valid (b_valid && !bus_gnt[i]),
            .snp_op    (b_op),
            .snp_addr  (b_addr),
            .snp_wdata (b_wdata),
            .snp_dirty (c_dirty[i]),
            .snp_data  (c_sdata[i]),
            .fill_data (fill)
        );
    end

    // R10: never more than one dirty owner answers a bus transaction
    assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> ($countones(c_dirty) <= 1))
        else $error("two dirty owners on one bus transaction");
endmodule

// File: tb/snoop_coherence_top_tb_top.sv
module snoop_coherence_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int MW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [N-1:0]    preq [2];
    logic [N-1:0]    pwe  [2];
    logic [N*AW-1:0] paddr[2];
    logic [N*DW-1:0] pwd  [2];
    logic [N-1:0]    pdone[2];
    logic [N*DW-1:0] prd  [2];
    logic [N-1:0]    gnt  [2];
    logic            mrd  [2];
    logic            mwr  [2];
    logic [AW-1:0]   maddr[2];
    logic [DW-1:0]   mwd  [2];
    logic [DW-1:0]   mrdata[2];
    logic [DW-1:0]   mem  [2][MW];
    logic [DW-1:0]   gold [2][MW];

    int checks = 0, fails = 0;
    int grants[2], mreads[2], mwrites[2];
    int glog[$];
    bit finished = 0;

    snoop_coherence_top #(.NCACHE(N), .ADDR_W(AW), .DATA_W(DW), .LINES(4), .UPDATE_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .proc_req(preq[0]), .proc_we(pwe[0]), .proc_addr(paddr[0]),
        .proc_wdata(pwd[0]), .proc_done(pdone[0]), .proc_rdata(prd[0]), .bus_gnt(gnt[0]),
        .mem_rd_en(mrd[0]), .mem_wr_en(mwr[0]), .mem_addr(maddr[0]), .mem_wdata(mwd[0]),
        .mem_rdata(mrdata[0]));

    snoop_coherence_top #(.NCACHE(N), .ADDR_W(AW), .DATA_W(DW), .LINES(4), .UPDATE_MODE(1'b1)) dut_u (
        .clk(clk), .rst_n(rst_n), .proc_req(preq[1]), .proc_we(pwe[1]), .proc_addr(paddr[1]),
        .proc_wdata(pwd[1]), .proc_done(pdone[1]), .proc_rdata(prd[1]), .bus_gnt(gnt[1]),
        .mem_rd_en(mrd[1]), .mem_wr_en(mwr[1]), .mem_addr(maddr[1]), .mem_wdata(mwd[1]),
        .mem_rdata(mrdata[1]));

    assign mrdata[0] = mem[0][maddr[0]];
    assign mrdata[1] = mem[1][maddr[1]];

    function automatic logic [DW-1:0] init_val(int a);
        return DW'(a) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                for (int a = 0; a < MW; a++) mem[d][a] <= init_val(a);
            end else if (mwr[d]) begin
                mem[d][maddr[d]] <= mwd[d];
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // per-clock monitor: grant shape (R8) and bus/memory activity counters
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                chk($onehot0(gnt[d]), "R8 grant one-hot", int'(gnt[d]), 1);
                if (gnt[d] != '0) begin
                    grants[d]++;
                    if (d == 0) begin
                        for (int c = 0; c < N; c++) if (gnt[d][c]) glog.push_back(c);
                    end
                end
                if (mrd[d]) mreads[d]++;
                if (mwr[d]) mwrites[d]++;
            end
        end
    end

    task automatic do_op(input int d, input int c, input bit we, input int a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        int n;
        @(negedge clk);
        preq[d][c] = 1'b1;
        pwe[d][c]  = we;
        paddr[d][c*AW +: AW] = AW'(a);
        pwd[d][c*DW +: DW]   = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pdone[d][c] && n < 400);
        rd = prd[d][c*DW +: DW];
        preq[d][c] = 1'b0;
        if (n >= 400) chk(1'b0, "R8 request completion", n, 0);
        if (we) gold[d][a] = wd;
    endtask

    // one operation with expected deltas in grants, memory reads, memory writes
    task automatic op_chk(input int d, input int c, input bit we, input int a,
                          input logic [DW-1:0] wd, input int eg, input int er,
                          input int ew, input string rq);
        logic [DW-1:0] rd;
        int g0, r0, w0;
        logic [DW-1:0] exp;
        exp = gold[d][a];
        g0 = grants[d]; r0 = mreads[d]; w0 = mwrites[d];
        do_op(d, c, we, a, wd, rd);
        if (!we) chk(rd == exp, {rq, " read data"}, int'(rd), int'(exp));
        chk(grants[d] - g0 == eg, {rq, " bus transactions"}, grants[d] - g0, eg);
        chk(mreads[d] - r0 == er, {rq, " memory reads"}, mreads[d] - r0, er);
        chk(mwrites[d] - w0 == ew, {rq, " memory writes"}, mwrites[d] - w0, ew);
    endtask

    localparam int A_ = 6'h05, B_ = 6'h09, D_ = 6'h0A, E_ = 6'h13, F_ = 6'h1E, G_ = 6'h23;

    initial begin
        logic [DW-1:0] r0, r1, r2;
        for (int d = 0; d < 2; d++) begin
            preq[d] = '0; pwe[d] = '0; paddr[d] = '0; pwd[d] = '0;
            grants[d] = 0; mreads[d] = 0; mwrites[d] = 0;
            for (int a = 0; a < MW; a++) gold[d][a] = init_val(a);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(pdone[d] == '0, "R1 reset done low", int'(pdone[d]), 0);
            chk(gnt[d] == '0, "R1 reset no grant", int'(gnt[d]), 0);
            chk(mwr[d] == 1'b0, "R1 reset no memory write", int'(mwr[d]), 0);
        end

        // invalidate mode
        op_chk(0, 0, 0, A_, 0,     1, 1, 0, "R1 read miss");
        op_chk(0, 0, 0, A_, 0,     0, 0, 0, "R2 read hit");
        op_chk(0, 1, 0, A_, 0,     1, 1, 0, "R1 second sharer");
        op_chk(0, 0, 1, A_, 8'h11, 1, 0, 0, "R3 write shared line invalidates");
        op_chk(0, 0, 1, A_, 8'h22, 0, 0, 0, "R11 write hit modified");
        op_chk(0, 1, 0, A_, 0,     1, 0, 1, "R5 owner supplies after R3 invalidate");
        chk(mem[0][A_] == 8'h22, "R5 memory updated by supply", int'(mem[0][A_]), 8'h22);
        op_chk(0, 0, 0, A_, 0,     0, 0, 0, "R5 former owner kept shared copy");
        op_chk(0, 2, 1, A_, 8'h33, 1, 1, 0, "R4 write miss");
        op_chk(0, 0, 0, A_, 0,     1, 0, 1, "R10 single owner supplies after R4");
        op_chk(0, 2, 1, A_, 8'h55, 1, 0, 0, "R3 write shared line");
        op_chk(0, 2, 1, B_, 8'h44, 2, 1, 1, "R6 dirty victim written back");
        chk(mem[0][A_] == 8'h55, "R6 victim data in memory", int'(mem[0][A_]), 8'h55);
        op_chk(0, 1, 0, A_, 0,     1, 1, 0, "R6 refetch from memory");
        op_chk(0, 0, 0, B_, 0,     1, 0, 1, "R5 owner supplies second line");
        chk(mem[0][B_] == 8'h44, "R5 memory updated", int'(mem[0][B_]), 8'h44);

        // round-robin order
        op_chk(0, 1, 0, D_, 0, 1, 1, 0, "R9 single request");
        glog.delete();
        fork
            do_op(0, 0, 0, E_, 0, r0);
            do_op(0, 1, 0, F_, 0, r1);
            do_op(0, 2, 0, G_, 0, r2);
        join
        chk(glog.size() == 3, "R9 grant count", glog.size(), 3);
        if (glog.size() == 3) begin
            chk(glog[0] == 2, "R9 first grant", glog[0], 2);
            chk(glog[1] == 0, "R9 second grant", glog[1], 0);
            chk(glog[2] == 1, "R9 third grant", glog[2], 1);
        end
        chk(r0 == gold[0][E_], "R9 data cache0", int'(r0), int'(gold[0][E_]));
        chk(r1 == gold[0][F_], "R9 data cache1", int'(r1), int'(gold[0][F_]));
        chk(r2 == gold[0][G_], "R9 data cache2", int'(r2), int'(gold[0][G_]));

        // update mode
        op_chk(1, 0, 0, A_, 0,     1, 1, 0, "R1 update-mode read miss");
        op_chk(1, 1, 0, A_, 0,     1, 1, 0, "R1 update-mode sharer");
        op_chk(1, 0, 1, A_, 8'h66, 1, 0, 1, "R7 write broadcast");
        chk(mem[1][A_] == 8'h66, "R7 memory written", int'(mem[1][A_]), 8'h66);
        op_chk(1, 1, 0, A_, 0,     0, 0, 0, "R7 sharer refreshed");
        op_chk(1, 0, 1, A_, 8'h77, 1, 0, 1, "R7 repeated write still broadcast");
        op_chk(1, 1, 0, A_, 0,     0, 0, 0, "R7 sharer refreshed again");
        op_chk(1, 2, 1, G_, 8'h12, 1, 0, 1, "R7 write miss broadcast");
        op_chk(1, 2, 0, G_, 0,     0, 0, 0, "R7 writer holds copy");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "R8 watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule